// File: doc/BRIEF.md
# Single-Address Peripheral-to-Memory DMA Channel

This block is one DMA channel that moves operands from a handshaking peripheral into memory without ever touching the data itself. The peripheral raises a request line; the channel answers by running a write cycle on a simple synchronous bus. During that cycle it raises an acknowledge strobe, which tells the peripheral to put its operand on the data bus, and it drives the destination address, a function code and the operand size. The channel's own data drivers stay off for the whole cycle.

Each bus cycle is either a standard three-clock access (phases S0, S2, S4) or a two-clock fast access in which S2 is skipped. In cycle-steal mode one operand moves per fresh request edge. In burst mode operands move back to back while the request stays high. When fast access and burst are combined, the channel inserts one idle clock after every operand and decides in that clock whether to run the next one. A byte counter sets the length of the block. A one-clock done strobe marks the last operand. Dropping the start input or raising the soft-reset input stops the channel at the next cycle boundary.

Top module: `sadma_channel`

## Requirements
- R1: While `rst` is high, and in the first clock after it, `ack_o`, `as_o`, `done_o`, `write_o` and `active_o` are low.
- R2: A rising edge on `start_i` while the channel is inactive and `soft_rst_i` is low loads the destination address and the byte count. `active_o` rises one clock later only if the loaded count is non-zero.
- R3: In every clock of a bus cycle, `ack_o`, `as_o` and `write_o` are high and `dbus_oe_o` is low. `addr_o` carries the current destination address, `fc_o` the configured function code, and `siz_o` the size code (0 = byte, 1 = 16-bit, 2 = 32-bit).
- R4: A bus cycle lasts three clocks with `fast_i` low and two clocks with `fast_i` high.
- R5: With `burst_i` low, one bus cycle runs per rising edge of `req_i` seen while the channel is idle. A request that stays high does not start a second cycle.
- R6: With `burst_i` high and `fast_i` low, a new cycle follows with no idle clock if `req_i` is high in the last clock of the previous cycle. Otherwise the channel goes idle.
- R7: With `burst_i` and `fast_i` both high, exactly one idle clock separates consecutive cycles, and `req_i` in that clock decides whether the next cycle runs. A cycle that has begun finishes even if `req_i` falls in the clock where acknowledge rises.
- R8: After each cycle the destination address grows by the operand size in bytes (1, 2 or 4) when `incr_i` is high, and stays the same when `incr_i` is low.
- R9: The byte count drops by the operand size after each cycle. In the final clock of the cycle that takes the count to zero (count not above the size), `done_o` is high for that one clock. `active_o` is low from the next clock on, and no further cycle runs.
- R10: With `soft_rst_i` high or `start_i` low, no new cycle starts and `active_o` falls at the next cycle boundary (idle clock or last clock of a cycle). A cycle already in progress still completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Channel enable; rising edge loads and arms |
| soft_rst_i | input | 1 | Channel abort |
| burst_i | input | 1 | 1 = burst, 0 = cycle steal |
| fast_i | input | 1 | 1 = two-clock access |
| incr_i | input | 1 | Destination address increment enable |
| size_i | input | 2 | Operand size code |
| fc_i | input | FC_W | Destination function code |
| dst_addr_i | input | ADDR_W | Initial destination address |
| byte_cnt_i | input | CNT_W | Block length in bytes |
| req_i | input | 1 | Peripheral service request |
| ack_o | output | 1 | Acknowledge to peripheral |
| done_o | output | 1 | Last-operand strobe |
| as_o | output | 1 | Address strobe |
| write_o | output | 1 | Write cycle indicator |
| dbus_oe_o | output | 1 | Channel data-bus drive enable (always off) |
| addr_o | output | ADDR_W | Destination address |
| fc_o | output | FC_W | Function code |
| siz_o | output | 2 | Operand size code on the bus |
| active_o | output | 1 | Channel active flag |

## Verification
The embedded properties assume that the mode inputs (`burst_i`, `fast_i`, `incr_i`, `size_i`, `fc_i`) stay constant while `active_o` is high, and that `size_i` never carries code 3. The bench changes configuration only between blocks, after the channel has stopped, and uses only the three legal size codes. Request edges are placed on clock boundaries relative to the known phase sequence, so every started cycle can be predicted exactly.

// File: rtl/sadma_pkg.sv
package sadma_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_FULL = 2'd2
    } opsize_e;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_S0,
        PH_S2,
        PH_S4,
        PH_GAP
    } phase_e;

    typedef struct packed {
        logic    burst;
        logic    fast;
        logic    incr;
        opsize_e size;
    } chan_mode_t;

    function automatic logic [2:0] size_bytes(opsize_e s);
        case (s)
            SZ_BYTE: size_bytes = 3'd1;
            SZ_HALF: size_bytes = 3'd2;
            default: size_bytes = 3'd4;
        endcase
    endfunction

endpackage

// File: rtl/sadma_bus_seq.sv
module sadma_bus_seq
    import sadma_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic active_i,
    input  logic abort_i,
    input  logic req_i,
    input  logic burst_i,
    input  logic fast_i,
    input  logic last_i,
    output logic cycle_o,
    output logic final_o,
    output logic boundary_o
);

    phase_e st_q, st_d;
    logic   req_q;
    logic   launch;

    // cycle steal needs a fresh edge, burst only a level
    assign launch = active_i && !abort_i && (burst_i ? req_i : (req_i && !req_q));

    always_comb begin
        st_d = st_q;
        case (st_q)
            PH_IDLE: if (launch) st_d = PH_S0;
            PH_S0:   st_d = fast_i ? PH_S4 : PH_S2;
            PH_S2:   st_d = PH_S4;
            PH_S4: begin
                if (last_i || abort_i || !burst_i)
                    st_d = PH_IDLE;
                else if (fast_i)
                    st_d = PH_GAP;
                else
                    st_d = req_i ? PH_S0 : PH_IDLE;
            end
            PH_GAP:  st_d = (active_i && !abort_i && req_i) ? PH_S0 : PH_IDLE;
            default: st_d = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= PH_IDLE;
            req_q <= 1'b0;
        end else begin
            st_q  <= st_d;
            req_q <= req_i;
        end
    end

    assign cycle_o    = (st_q == PH_S0) || (st_q == PH_S2) || (st_q == PH_S4);
    assign final_o    = (st_q == PH_S4);
    assign boundary_o = (st_q == PH_IDLE) || (st_q == PH_GAP) || (st_q == PH_S4);

    // R4
    fast_skip_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q == PH_S0 && fast_i) |=> (st_q == PH_S4));

    // R4
    std_mid_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q == PH_S0 && !fast_i) |=> (st_q == PH_S2));

    // R7
    fast_gap_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q == PH_S4 && burst_i && fast_i && !last_i && !abort_i) |=> (st_q == PH_GAP));

    // R5
    steal_stop_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q == PH_S4 && !burst_i) |=> (st_q == PH_IDLE));

endmodule

// File: rtl/sadma_chan_regs.sv
module sadma_chan_regs
    import sadma_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic              soft_rst_i,
    input  logic              incr_i,
    input  opsize_e           size_i,
    input  logic [ADDR_W-1:0] addr_init_i,
    input  logic [CNT_W-1:0]  cnt_init_i,
    input  logic              xfer_end_i,
    input  logic              boundary_i,
    output logic              active_o,
    output logic              last_o,
    output logic [ADDR_W-1:0] addr_o
);

    logic [ADDR_W-1:0] addr_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              active_q;
    logic              start_q;
    logic              abort;
    logic [CNT_W-1:0]  step_c;
    logic [ADDR_W-1:0] step_a;

    assign abort  = soft_rst_i || !start_i;
    assign step_c = CNT_W'(size_bytes(size_i));
    assign step_a = ADDR_W'(size_bytes(size_i));
    assign last_o = (cnt_q <= step_c);

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q   <= '0;
            cnt_q    <= '0;
            active_q <= 1'b0;
            start_q  <= 1'b0;
        end else begin
            start_q <= start_i;
            if (!active_q) begin
                if (start_i && !start_q && !soft_rst_i) begin
                    addr_q   <= addr_init_i;
                    cnt_q    <= cnt_init_i;
                    active_q <= (cnt_init_i != '0);
                end
            end else begin
                if (xfer_end_i) begin
                    if (incr_i) addr_q <= addr_q + step_a;
                    cnt_q <= last_o ? '0 : (cnt_q - step_c);
                    if (last_o) active_q <= 1'b0;
                end
                if (abort && boundary_i) active_q <= 1'b0;
            end
        end
    end

    assign active_o = active_q;
    assign addr_o   = addr_q;

    // R2
    arm_chk: assert property (@(posedge clk) disable iff (rst)
        (start_i && !start_q && !active_q && !soft_rst_i && cnt_init_i != '0) |=> active_q);

    // R8
    hold_addr_chk: assert property (@(posedge clk) disable iff (rst)
        (active_q && xfer_end_i && !incr_i) |=> $stable(addr_q));

    // R9
    final_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (active_q && xfer_end_i && last_o) |=> !active_q);

    // R10
    abort_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (active_q && abort && boundary_i) |=> !active_q);

endmodule

// File: rtl/sadma_channel.sv
module sadma_channel
    import sadma_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16,
    parameter int FC_W   = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic              soft_rst_i,
    input  logic              burst_i,
    input  logic              fast_i,
    input  logic              incr_i,
    input  logic [1:0]        size_i,
    input  logic [FC_W-1:0]   fc_i,
    input  logic [ADDR_W-1:0] dst_addr_i,
    input  logic [CNT_W-1:0]  byte_cnt_i,
    input  logic              req_i,
    output logic              ack_o,
    output logic              done_o,
    output logic              as_o,
    output logic              write_o,
    output logic              dbus_oe_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic [FC_W-1:0]   fc_o,
    output logic [1:0]        siz_o,
    output logic              active_o
);

    chan_mode_t mode;
    logic       active, last, cycle, fin, boundary, abort;

    assign mode.burst = burst_i;
    assign mode.fast  = fast_i;
    assign mode.incr  = incr_i;
    assign mode.size  = opsize_e'(size_i);
    assign abort      = soft_rst_i || !start_i;

    sadma_chan_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) i_regs (
        .clk        (clk),
        .rst        (rst),
        .start_i    (start_i),
        .soft_rst_i (soft_rst_i),
        .incr_i     (mode.incr),
        .size_i     (mode.size),
        .addr_init_i(dst_addr_i),
        .cnt_init_i (byte_cnt_i),
        .xfer_end_i (fin),
        .boundary_i (boundary),
        .active_o   (active),
        .last_o     (last),
        .addr_o     (addr_o)
    );

    sadma_bus_seq i_seq (
        .clk        (clk),
        .rst        (rst),
        .active_i   (active),
        .abort_i    (abort),
        .req_i      (req_i),
        .burst_i    (mode.burst),
        .fast_i     (mode.fast),
        .last_i     (last),
        .cycle_o    (cycle),
        .final_o    (fin),
        .boundary_o (boundary)
    );

    assign ack_o     = cycle;
    assign as_o      = cycle;
    assign write_o   = cycle;
    assign dbus_oe_o = 1'b0;
    assign done_o    = fin && last;
    assign fc_o      = fc_i;
    assign siz_o     = size_i;
    assign active_o  = active;

    // R9
    done_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !ack_o);

endmodule

// File: tb/test_sadma_channel.sv
module test_sadma_channel;

    localparam int ADDR_W = 32;
    localparam int CNT_W  = 16;
    localparam int FC_W   = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start_i = 0, soft_rst_i = 0, burst_i = 0, fast_i = 0, incr_i = 0, req_i = 0;
    logic [1:0]        size_i = 0;
    logic [FC_W-1:0]   fc_i = 0;
    logic [ADDR_W-1:0] dst_addr_i = 0;
    logic [CNT_W-1:0]  byte_cnt_i = 0;
    logic ack_o, done_o, as_o, write_o, dbus_oe_o, active_o;
    logic [ADDR_W-1:0] addr_o;
    logic [FC_W-1:0]   fc_o;
    logic [1:0]        siz_o;

    always #4 clk = ~clk;

    sadma_channel #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .FC_W(FC_W)) i_sadma_channel (
        .clk(clk), .rst(rst), .start_i(start_i), .soft_rst_i(soft_rst_i),
        .burst_i(burst_i), .fast_i(fast_i), .incr_i(incr_i), .size_i(size_i),
        .fc_i(fc_i), .dst_addr_i(dst_addr_i), .byte_cnt_i(byte_cnt_i), .req_i(req_i),
        .ack_o(ack_o), .done_o(done_o), .as_o(as_o), .write_o(write_o),
        .dbus_oe_o(dbus_oe_o), .addr_o(addr_o), .fc_o(fc_o), .siz_o(siz_o),
        .active_o(active_o)
    );

    typedef struct {
        logic [ADDR_W-1:0] addr;
        logic [FC_W-1:0]   fc;
        logic [1:0]        siz;
        int                len;
        int                gap;
        bit                last;
    } exp_t;

    exp_t q[$];
    exp_t cur;
    int   vectors = 0, errors = 0;
    int   rem = 0, idle = 1000;
    bit   mon_en = 0, finished = 0;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        vectors++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic expect_xfer(input logic [ADDR_W-1:0] a, input int len, input int gap, input bit last);
        exp_t e;
        e.addr = a; e.fc = fc_i; e.siz = size_i; e.len = len; e.gap = gap; e.last = last;
        q.push_back(e);
    endtask

    // monitor: pops one expected item per bus cycle
    always @(negedge clk) if (mon_en) begin
        if (ack_o) begin
            if (rem == 0) begin
                if (q.size() == 0) begin
                    chk(0, "R5/R9/R10 unexpected cycle", 1, 0);
                    rem = -1;
                end else begin
                    cur = q.pop_front();
                    rem = cur.len;
                    if (cur.gap >= 0) chk(idle == cur.gap, "R6/R7 idle clocks between cycles", idle, cur.gap);
                end
            end
            if (rem > 0) begin
                chk(addr_o == cur.addr, "R3/R8 address", addr_o, cur.addr);
                chk(fc_o == cur.fc && siz_o == cur.siz, "R3 fc/size", {fc_o, siz_o}, {cur.fc, cur.siz});
                chk(as_o && write_o && !dbus_oe_o, "R3 strobes", {as_o, write_o, dbus_oe_o}, 3'b110);
                rem--;
                chk(done_o == (rem == 0 && cur.last), "R9 done strobe", done_o, (rem == 0 && cur.last));
                if (rem == 0) idle = 0;
            end
        end else begin
            if (rem > 0) chk(0, "R4 cycle ended early", cur.len - rem, cur.len);
            rem = 0;
            idle++;
        end
    end

    task automatic clocks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic arm(input bit b, input bit f, input bit inc, input logic [1:0] sz,
                       input logic [FC_W-1:0] fc, input logic [ADDR_W-1:0] a, input logic [CNT_W-1:0] c);
        @(negedge clk);
        start_i = 0; burst_i = b; fast_i = f; incr_i = inc; size_i = sz;
        fc_i = fc; dst_addr_i = a; byte_cnt_i = c;
        @(negedge clk);
        start_i = 1;
        @(negedge clk);
        chk(active_o == (c != 0), "R2 channel armed", active_o, (c != 0));
    endtask

    task automatic pulse_req();
        @(negedge clk); req_i = 1;
        @(negedge clk); req_i = 0;
        clocks(6);
    endtask

    task automatic settle(input string tag);
        clocks(4);
        chk(q.size() == 0, tag, q.size(), 0);
    endtask

    initial begin
        clocks(3);
        chk(!ack_o && !as_o && !done_o && !write_o && !active_o, "R1 outputs in reset",
            {ack_o, as_o, done_o, write_o, active_o}, 0);
        rst = 0;
        @(negedge clk);
        chk(!ack_o && !as_o && !done_o && !active_o, "R1 after reset", {ack_o, as_o, done_o, active_o}, 0);
        mon_en = 1;

        // cycle steal, standard, byte, incrementing
        arm(0, 0, 1, 2'd0, 3'd5, 32'h1000, 16'd3);
        expect_xfer(32'h1000, 3, -1, 0); pulse_req();
        expect_xfer(32'h1001, 3, -1, 0); pulse_req();
        expect_xfer(32'h1002, 3, -1, 1); pulse_req();
        chk(!active_o, "R9 inactive after final", active_o, 0);
        pulse_req();
        settle("R5 all steal cycles seen");

        // cycle steal, fast, 16-bit, fixed address, held request
        arm(0, 1, 0, 2'd1, 3'd3, 32'h2000, 16'd8);
        expect_xfer(32'h2000, 2, -1, 0);
        @(negedge clk); req_i = 1;
        clocks(20);
        req_i = 0;
        expect_xfer(32'h2000, 2, -1, 0); pulse_req();
        chk(active_o, "R9 still active with bytes left", active_o, 1);
        start_i = 0;
        clocks(2);
        chk(!active_o, "R10 start cleared", active_o, 0);
        pulse_req();
        settle("R5 held request gives one cycle");

        // standard burst, 32-bit, runs to completion
        arm(1, 0, 1, 2'd2, 3'd1, 32'h3000, 16'd16);
        expect_xfer(32'h3000, 3, -1, 0);
        expect_xfer(32'h3004, 3, 0, 0);
        expect_xfer(32'h3008, 3, 0, 0);
        expect_xfer(32'h300C, 3, 0, 1);
        @(negedge clk); req_i = 1;
        clocks(20);
        chk(!active_o, "R9 burst ended on count", active_o, 0);
        req_i = 0;
        settle("R6 back-to-back burst");

        // standard burst, request drops after two cycles, then soft reset
        arm(1, 0, 1, 2'd2, 3'd2, 32'h5000, 16'd40);
        expect_xfer(32'h5000, 3, -1, 0);
        expect_xfer(32'h5004, 3, 0, 0);
        @(negedge clk); req_i = 1;
        clocks(4);
        req_i = 0;
        clocks(6);
        chk(active_o, "R6 idle but still active", active_o, 1);
        soft_rst_i = 1;
        @(negedge clk); soft_rst_i = 0;
        chk(!active_o, "R10 soft reset", active_o, 0);
        pulse_req();
        settle("R6 burst stops on low request");

        // fast burst, 16-bit, one idle clock between cycles
        arm(1, 1, 1, 2'd1, 3'd6, 32'h4000, 16'd6);
        expect_xfer(32'h4000, 2, -1, 0);
        expect_xfer(32'h4002, 2, 1, 0);
        expect_xfer(32'h4004, 2, 1, 1);
        @(negedge clk); req_i = 1;
        clocks(15);
        req_i = 0;
        settle("R7 fast burst spacing");

        // fast burst, request falls as acknowledge rises
        arm(1, 1, 1, 2'd0, 3'd4, 32'h6000, 16'd20);
        expect_xfer(32'h6000, 2, -1, 0);
        @(negedge clk); req_i = 1;
        @(negedge clk); req_i = 0;
        chk(ack_o, "R7 cycle runs despite request drop", ack_o, 1);
        clocks(6);
        expect_xfer(32'h6001, 2, -1, 0); pulse_req();
        chk(active_o, "R7 still active", active_o, 1);
        start_i = 0;
        settle("R7 coincident request drop");

        // zero count never activates
        arm(0, 0, 1, 2'd0, 3'd0, 32'h8000, 16'd0);
        pulse_req();
        settle("R2 zero count idle");

        // abort during a standard cycle lets it complete
        arm(0, 0, 1, 2'd2, 3'd7, 32'h7000, 16'd10);
        expect_xfer(32'h7000, 3, -1, 0);
        @(negedge clk); req_i = 1;
        @(negedge clk); req_i = 0;
        @(negedge clk); start_i = 0;
        clocks(3);
        chk(!active_o, "R10 abort after cycle", active_o, 0);
        pulse_req();
        settle("R10 in-flight cycle completes");

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            vectors++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

endmodule